// File: doc/BRIEF.md
# Dual-Phase Pulse-Width Capture Unit

This block times a duty-cycle-modulated sensor signal entirely in hardware, so no processor has to watch the pin. A prescaler turns the system clock into a measurement tick, 1 MHz by default. One shared up counter counts these ticks. At each transition of the synchronized input, the counter value is written into one of two result registers and the counter is then cleared. The polarity the input has just taken decides the target: a falling edge closes a high phase, and a rising edge closes a low phase.

The high-time and low-time results are held side by side and can be read at any time. Each result keeps its last value until its own next capture. A one-cycle strobe marks each low-time update, which closes one full period. A per-register valid bit shows that a register has been written at least once since reset.

A valid phase never reaches half the counter range. A set counter MSB therefore means the input is stuck or disconnected, and it raises an error flag. The counter saturates instead of wrapping, so the last result is at most all-ones.

Top module: `duty_capture`

## Requirements
- R1: While reset is asserted and until the first capture, every output is 0 (results, valid bits, strobe, error).
- R2: A falling input edge writes the counter into `hi_time_o`, and a rising edge writes it into `lo_time_o`. The counter is cleared to 0 after each capture. With one tick per clock, a phase lasting D clocks is captured as D−2.
- R3: A result register changes only at a capture of its own polarity. At every other time it keeps its value.
- R4: `period_o` is high for exactly one cycle, and it is high in the same cycle as the first appearance of a new `lo_time_o` value. It is never high for a high-time update.
- R5: A new result appears on the fourth rising clock edge after the input changes and not earlier. The counter clear follows one edge after the capture.
- R6: The counter stops at all-ones and does not wrap. A phase longer than the range is captured as all-ones.
- R7: `fault_o` goes high within one cycle of the counter MSB becoming 1. It stays high while the input does not change, and it is 0 from the capture that ends the phase onward.
- R8: `hi_valid_o` and `lo_valid_o` are set by the first capture into their register and stay set until reset.
- R9: The counter advances once every TICK_DIV clocks. With TICK_DIV=4, a high phase of 200 clocks is captured as 48 to 50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sens_i | input | 1 | Asynchronous duty-cycle sensor input |
| hi_time_o | output | CNT_W | Last captured high-phase length in ticks |
| lo_time_o | output | CNT_W | Last captured low-phase length in ticks |
| hi_valid_o | output | 1 | High-time register has been written |
| lo_valid_o | output | 1 | Low-time register has been written |
| period_o | output | 1 | One-cycle strobe on each low-time update |
| fault_o | output | 1 | Stuck or disconnected input (counter MSB reached) |

## Verification
The bench drives phases of known length and checks the exact capture value. It also checks in the cycle before the update that the old value is still present. A design that captured after the clear, or one cycle early, would show a wrong count or an early update. The bench samples the other register at each capture, so a polarity mix-up or a write to both registers gets caught. It holds the input long enough to cross the MSB and then the top of the range: a wrapping counter would return a small value, and an error flag that was not cleared on capture, or was set again by the stale count during the clear cycle, would still read high afterwards. A phase of only six clocks exercises the shortest spacing of capture and clear that the bench covers.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  // Capture request raised one cycle after a synchronized input edge.
  typedef struct packed {
    logic fire;    // an edge was seen
    logic rising;  // new level is high: the low phase just ended
  } cap_req_t;

endpackage

// File: rtl/pwc_rst_sync.sv
module pwc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] rs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end

  assign rst_no = rs_q[1];

endmodule

// File: rtl/pwc_in_sync.sv
module pwc_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic edge_o
);

  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain_q, chain_d;
  logic         last_q, last_d;

  always_comb begin
    chain_d = {chain_q[N-2:0], async_i};
    last_d  = chain_q[N-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= last_d;
    end
  end

  assign level_o = chain_q[N-1];
  assign edge_o  = chain_q[N-1] ^ last_q;

endmodule

// File: rtl/pwc_tick.sv
module pwc_tick #(
  parameter int unsigned DIV = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  generate
    if (DIV <= 1) begin : g_every
      logic on_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) on_q <= 1'b0;
        else         on_q <= 1'b1;
      end
      assign tick_o = on_q;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q, pre_d;

      always_comb begin
        if (pre_q == LAST) pre_d = '0;
        else               pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_d;
      end

      assign tick_o = (pre_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/pwc_counter.sv
module pwc_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o,
  output logic         msb_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         full;

  assign full = &cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)               cnt_d = '0;
    else if (tick_i && !full) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign msb_o = cnt_q[W-1];

endmodule

// File: rtl/pwc_phase_regs.sv
module pwc_phase_regs
  import pwc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  cap_req_t     cap_i,
  input  logic [W-1:0] cnt_i,
  input  logic         msb_i,
  input  logic         clr_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic         hi_vld_o,
  output logic         lo_vld_o,
  output logic         stb_o,
  output logic         err_o
);

  logic [W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic         hv_q, hv_d, lv_q, lv_d;
  logic         stb_q, stb_d, err_q, err_d;

  always_comb begin
    hi_d  = hi_q;
    lo_d  = lo_q;
    hv_d  = hv_q;
    lv_d  = lv_q;
    stb_d = 1'b0;
    err_d = err_q;
    if (cap_i.fire) begin
      if (cap_i.rising) begin
        lo_d  = cnt_i;
        lv_d  = 1'b1;
        stb_d = 1'b1;
      end else begin
        hi_d = cnt_i;
        hv_d = 1'b1;
      end
      err_d = 1'b0;
    end else if (msb_i && !clr_i) begin
      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      hv_q  <= 1'b0;
      lv_q  <= 1'b0;
      stb_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      hv_q  <= hv_d;
      lv_q  <= lv_d;
      stb_q <= stb_d;
      err_q <= err_d;
    end
  end

  assign hi_o     = hi_q;
  assign lo_o     = lo_q;
  assign hi_vld_o = hv_q;
  assign lo_vld_o = lv_q;
  assign stb_o    = stb_q;
  assign err_o    = err_q;

endmodule

// File: rtl/duty_capture.sv
module duty_capture
  import pwc_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned TICK_DIV    = 200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sens_i,
  output logic [CNT_W-1:0] hi_time_o,
  output logic [CNT_W-1:0] lo_time_o,
  output logic             hi_valid_o,
  output logic             lo_valid_o,
  output logic             period_o,
  output logic             fault_o
);

  logic             rst_n_int;
  logic             level, edge_seen, tick;
  logic [CNT_W-1:0] cnt;
  logic             cnt_msb;
  cap_req_t         cap_q, cap_d;
  logic             clr_q, clr_d;

  pwc_rst_sync i_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  pwc_in_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .async_i (sens_i),
    .level_o (level),
    .edge_o  (edge_seen)
  );

  pwc_tick #(.DIV(TICK_DIV)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .tick_o (tick)
  );

  pwc_counter #(.W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .tick_i (tick),
    .clr_i  (clr_q),
    .cnt_o  (cnt),
    .msb_o  (cnt_msb)
  );

  // Edge -> capture (next cycle) -> clear (cycle after)
  always_comb begin
    cap_d.fire   = edge_seen;
    cap_d.rising = level;
    clr_d        = cap_q.fire;
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      cap_q <= '0;
      clr_q <= 1'b0;
    end else begin
      cap_q <= cap_d;
      clr_q <= clr_d;
    end
  end

  pwc_phase_regs #(.W(CNT_W)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .cap_i    (cap_q),
    .cnt_i    (cnt),
    .msb_i    (cnt_msb),
    .clr_i    (clr_q),
    .hi_o     (hi_time_o),
    .lo_o     (lo_time_o),
    .hi_vld_o (hi_valid_o),
    .lo_vld_o (lo_valid_o),
    .stb_o    (period_o),
    .err_o    (fault_o)
  );

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_n,
  input logic         cap_fire,
  input logic         cap_rise,
  input logic         clr,
  input logic [W-1:0] cnt,
  input logic [W-1:0] hi,
  input logic [W-1:0] lo,
  input logic         hi_vld,
  input logic         lo_vld,
  input logic         stb,
  input logic         err
);

  a_r3_hi_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(cap_fire && !cap_rise) |=> $stable(hi));

  a_r3_lo_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(cap_fire && cap_rise) |=> $stable(lo));

  a_r4_stb_after_lo: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cap_fire && cap_rise) |=> stb);

  a_r4_stb_only_lo: assert property (@(posedge clk_i) disable iff (!rst_n)
    stb |-> $past(cap_fire && cap_rise));

  a_r5_clear_after_capture: assert property (@(posedge clk_i) disable iff (!rst_n)
    cap_fire |=> clr);

  a_r6_saturate: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((&cnt) && !clr) |=> (&cnt));

  a_r7_err_clear: assert property (@(posedge clk_i) disable iff (!rst_n)
    cap_fire |=> !err);

  a_r8_hi_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_n)
    hi_vld |=> hi_vld);

  a_r8_lo_valid_sticky: assert property (@(posedge clk_i) disable iff (!rst_n)
    lo_vld |=> lo_vld);

endmodule

bind duty_capture pwc_checker #(.W(CNT_W)) i_pwc_checker (
  .clk_i    (clk_i),
  .rst_n    (rst_n_int),
  .cap_fire (cap_q.fire),
  .cap_rise (cap_q.rising),
  .clr      (clr_q),
  .cnt      (cnt),
  .hi       (hi_time_o),
  .lo       (lo_time_o),
  .hi_vld   (hi_valid_o),
  .lo_vld   (lo_valid_o),
  .stb      (period_o),
  .err      (fault_o)
);

// File: tb/test_duty_capture.sv
module test_duty_capture;

  localparam int W   = 10;
  localparam int MAX = (1 << W) - 1;

  logic         clk, rst_n, sens;
  logic [W-1:0] hi_t, lo_t, d_hi, d_lo;
  logic         hi_v, lo_v, stb, flt;
  logic         d_hv, d_lv, d_stb, d_flt;

  int checks = 0;
  int fails  = 0;
  int exp_hi = 0;
  int exp_lo = 0;

  duty_capture #(.CNT_W(W), .TICK_DIV(1)) i_duty_capture (
    .clk_i(clk), .rst_ni(rst_n), .sens_i(sens),
    .hi_time_o(hi_t), .lo_time_o(lo_t), .hi_valid_o(hi_v),
    .lo_valid_o(lo_v), .period_o(stb), .fault_o(flt)
  );

  duty_capture #(.CNT_W(W), .TICK_DIV(4)) i_duty_capture_div (
    .clk_i(clk), .rst_ni(rst_n), .sens_i(sens),
    .hi_time_o(d_hi), .lo_time_o(d_lo), .hi_valid_o(d_hv),
    .lo_valid_o(d_lv), .period_o(d_stb), .fault_o(d_flt)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Drive level lvl for len clocks; check capture of previous phase (prev clocks).
  task automatic run_phase(input logic lvl, input int len, input int prev,
                           input bit known);
    int ev;
    ev = prev - 2;
    if (ev > MAX) ev = MAX;
    sens = lvl;
    repeat (3) @(negedge clk);
    if (known) begin
      if (lvl) check_eq("R5 lo not yet updated", int'(lo_t), exp_lo);
      else     check_eq("R5 hi not yet updated", int'(hi_t), exp_hi);
    end
    @(negedge clk);
    if (lvl) begin
      if (known) begin
        check_eq("R2 lo capture", int'(lo_t), ev);
        exp_lo = ev;
      end else begin
        exp_lo = int'(lo_t);
      end
      check_eq("R3 hi held on rising", int'(hi_t), exp_hi);
      check_eq("R4 strobe on lo update", int'(stb), 1);
    end else begin
      check_eq("R2 hi capture", int'(hi_t), ev);
      exp_hi = ev;
      check_eq("R3 lo held on falling", int'(lo_t), exp_lo);
      check_eq("R4 no strobe on hi update", int'(stb), 0);
    end
    check_eq("R7 fault clear after capture", int'(flt), 0);
    @(negedge clk);
    check_eq("R4 strobe one cycle", int'(stb), 0);
    repeat (len - 5) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    sens  = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R1 hi reset", int'(hi_t), 0);
    check_eq("R1 lo reset", int'(lo_t), 0);
    check_eq("R1 valid reset", int'({hi_v, lo_v}), 0);
    check_eq("R1 strobe/fault reset", int'({stb, flt}), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check_eq("R1 idle after reset", int'({hi_v, lo_v, stb, flt}), 0);
  endtask

  task automatic t_first();
    run_phase(1'b1, 30, 0, 1'b0);
    check_eq("R8 lo valid after first rise", int'(lo_v), 1);
    check_eq("R8 hi not valid yet", int'(hi_v), 0);
  endtask

  task automatic t_measure();
    run_phase(1'b0, 40, 30, 1'b1);
    check_eq("R8 hi valid", int'(hi_v), 1);
    run_phase(1'b1, 25, 40, 1'b1);
    run_phase(1'b0, 7, 25, 1'b1);
    run_phase(1'b1, 200, 7, 1'b1);
    run_phase(1'b0, 60, 200, 1'b1);
    checks++;
    if (int'(d_hi) < 48 || int'(d_hi) > 50) begin
      fails++;
      $display("FAIL R9 divided hi: actual %0d expected 48..50", d_hi);
    end
    run_phase(1'b1, 6, 60, 1'b1);
  endtask

  task automatic t_stuck();
    sens = 1'b0;
    repeat (4) @(negedge clk);
    check_eq("R2 short hi capture", int'(hi_t), 4);
    exp_hi = 4;
    repeat (496) @(negedge clk);
    check_eq("R7 no fault below MSB", int'(flt), 0);
    repeat (30) @(negedge clk);
    check_eq("R7 fault after MSB", int'(flt), 1);
    repeat (570) @(negedge clk);
    check_eq("R7 fault held", int'(flt), 1);
    check_eq("R3 lo held while stuck", int'(lo_t), exp_lo);
    run_phase(1'b1, 20, 1100, 1'b1);
    check_eq("R6 saturated capture", int'(lo_t), MAX);
    run_phase(1'b0, 10, 20, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_first();
    t_measure();
    t_stuck();
    summary();
    $finish;
  end

endmodule